// File: doc/BRIEF.md
# Receive Buffer Credit Tracker

This block keeps, for each receive/transmit channel pair of a DMA controller, a running count of the free receive buffers that software has handed over. Software adds buffers by writing a credit amount into a per-tracker allocation register. Each time the DMA engine completes a receive descriptor, it pulses a consume input tagged with its channel number, and one credit is taken from the tracker that serves that channel. The tracker index is the channel number shifted right by one. Only the even (receive) channel of a pair consumes credits.

Each tracker drives a pause output with hysteresis. The output rises when the credit count drops below a programmable low threshold. It falls again only once the count has climbed back to the programmable high threshold. A force bit in the allocation register parks a tracker while its channel is being shut down: the count is held at zero and pause is held low. A global configuration register holds a controller-wide enable and one enable per tracker, and pause is only driven while both are set.

The consume input is a plain single-cycle pulse with no ready signal. The block cannot refuse it, so every pulse is counted in the cycle it arrives. The register port also has no back-pressure: a write is accepted in the cycle `reg_we` is high, and a read returns data in the same cycle.

Top module: `rxfc_tracker`

## Requirements
- R1: After reset every register reads 0 (credit count, thresholds, force flag, overrun flag and the configuration), and `pause_o` and `overrun_o` are all 0.
- R2: Register map:
  - The configuration register sits at address 0x00. Bit 0 is the global enable and bit k+1 enables tracker k. Higher bits read 0.
  - Tracker k has its low threshold at 0x04+0x0C*k, its high threshold at 0x08+0x0C*k and its allocation register at 0x0C+0x0C*k.
  - Thresholds read back in bits [CNT_W-1:0].
  - An address outside this map reads 0, and a write to it changes nothing.
- R3: A write to an allocation register with bit 31 clear adds `wdata[CNT_W-1:0]` to that tracker's count. The count saturates at 2^CNT_W-1. The count reads back in bits [CNT_W-1:0] of the allocation register from the cycle after the write.
- R4: A consume pulse on an even channel c lowers the count of tracker c>>1 by one. A pulse on an odd channel changes no count.
- R5: A consume pulse that finds a count of 0 (with no credit added in the same cycle) leaves the count at 0 and sets that tracker's overrun flag. The flag appears as `overrun_o[k]` and as bit 30 of the allocation register. It stays set until a force write.
- R6: An allocation write and a consume pulse to the same tracker in the same cycle change the count by their net effect. An add of 1 against a count of 0 therefore gives 0 and does not set overrun.
- R7: One cycle after the count is below the low threshold, `pause_o[k]` is 1. It then stays 1 until the cycle after the count is at or above the high threshold.
- R8: Force behaviour:
  - A write to an allocation register with bit 31 set zeroes the count, clears overrun and sets the force flag (bit 31 of the allocation register). Pause is then 0 from the next cycle.
  - While the force flag is set, consume pulses are ignored.
  - A write with bit 31 clear leaves the force state and adds its credit.
- R9: `pause_o[k]` is 0 in any cycle that follows a cycle in which the global enable or the enable of tracker k was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | ADDR_W | Register read byte address |
| reg_rdata | output | 32 | Register read data, same cycle |
| cons_valid | input | 1 | Receive descriptor completed (one-cycle pulse) |
| cons_chan | input | CH_W | Channel of the completed descriptor |
| pause_o | output | NUM_TRK | Flow-control pause, one per tracker |
| overrun_o | output | NUM_TRK | Sticky overrun flag, one per tracker |

## Verification
A wrong credit count is visible in the allocation register in the very next cycle. It also shows one cycle later as a pause edge in the wrong place, because pause follows the count with a single register of delay. A hysteresis state that is lost or stuck shows as `pause_o` changing in the band between the thresholds. It can also show as `pause_o` failing to rise once the count drops below the low threshold. A wrong force or overrun flag shows immediately in the top bits of the allocation register, and through consume pulses that are ignored, or not ignored, in the next cycle.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int REG_W      = 32;
  localparam int FORCE_BIT  = 31;
  localparam int OVR_BIT    = 30;
  localparam int CFG_OFFS   = 0;
  localparam int TRK_FIRST  = 4;
  localparam int TRK_STRIDE = 12;

  typedef enum logic [1:0] {
    FLD_LOW   = 2'd0,
    FLD_HIGH  = 2'd1,
    FLD_ALLOC = 2'd2
  } trk_field_e;

  function automatic int field_addr(input int trk, input trk_field_e fld);
    return TRK_FIRST + TRK_STRIDE * trk + 4 * int'(fld);
  endfunction
endpackage

// File: rtl/rxfc_decode.sv
module rxfc_decode
  import rxfc_pkg::*;
#(
  parameter int NUM_TRK = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               qual,
  output logic               cfg_hit,
  output logic [NUM_TRK-1:0] low_hit,
  output logic [NUM_TRK-1:0] high_hit,
  output logic [NUM_TRK-1:0] alloc_hit
);
  assign cfg_hit = qual && (addr == ADDR_W'(CFG_OFFS));

  for (genvar k = 0; k < NUM_TRK; k++) begin : g_trk
    localparam int LOW_A   = field_addr(k, FLD_LOW);
    localparam int HIGH_A  = field_addr(k, FLD_HIGH);
    localparam int ALLOC_A = field_addr(k, FLD_ALLOC);
    assign low_hit[k]   = qual && (addr == ADDR_W'(LOW_A));
    assign high_hit[k]  = qual && (addr == ADDR_W'(HIGH_A));
    assign alloc_hit[k] = qual && (addr == ADDR_W'(ALLOC_A));
  end
endmodule

// File: rtl/rxfc_credit_unit.sv
module rxfc_credit_unit
  import rxfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_we,
  input  logic             high_we,
  input  logic             alloc_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             consume,
  input  logic             trk_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q,
  output logic             force_q,
  output logic             ovr_q,
  output logic             pause_q
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic             force_wr, add_wr, take;
  logic [SUM_W-1:0] gross, net;
  logic             starve;
  logic [CNT_W-1:0] cnt_d;
  logic             pause_d;

  assign force_wr = alloc_we && wdata[FORCE_BIT];
  assign add_wr   = alloc_we && !wdata[FORCE_BIT];
  assign take     = consume && !force_q;

  always_comb begin
    gross  = {2'b00, cnt_q} + (add_wr ? {2'b00, wdata[CNT_W-1:0]} : '0);
    starve = take && (gross == '0);
    net    = (take && !starve) ? gross - SUM_W'(1) : gross;
    cnt_d  = (net > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : net[CNT_W-1:0];
  end

  always_comb begin
    pause_d = pause_q;
    if (!trk_en || force_q) pause_d = 1'b0;
    else if (cnt_q < low_q) pause_d = 1'b1;
    else if (cnt_q >= high_q) pause_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      low_q   <= '0;
      high_q  <= '0;
      force_q <= 1'b0;
      ovr_q   <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      pause_q <= pause_d;
      if (low_we)  low_q  <= wdata[CNT_W-1:0];
      if (high_we) high_q <= wdata[CNT_W-1:0];
      if (force_wr) begin
        cnt_q   <= '0;
        force_q <= 1'b1;
        ovr_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        if (add_wr) force_q <= 1'b0;
        if (starve) ovr_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxfc_readmux.sv
module rxfc_readmux
  import rxfc_pkg::*;
#(
  parameter int NUM_TRK = 4,
  parameter int CNT_W   = 8
) (
  input  logic                          cfg_hit,
  input  logic [NUM_TRK-1:0]            low_hit,
  input  logic [NUM_TRK-1:0]            high_hit,
  input  logic [NUM_TRK-1:0]            alloc_hit,
  input  logic [NUM_TRK:0]              cfg_q,
  input  logic [NUM_TRK-1:0][CNT_W-1:0] cnt_vec,
  input  logic [NUM_TRK-1:0][CNT_W-1:0] low_vec,
  input  logic [NUM_TRK-1:0][CNT_W-1:0] high_vec,
  input  logic [NUM_TRK-1:0]            force_vec,
  input  logic [NUM_TRK-1:0]            ovr_vec,
  output logic [REG_W-1:0]              rdata
);
  always_comb begin
    rdata = cfg_hit ? REG_W'(cfg_q) : '0;
    for (int k = 0; k < NUM_TRK; k++) begin
      if (low_hit[k])  rdata = rdata | REG_W'(low_vec[k]);
      if (high_hit[k]) rdata = rdata | REG_W'(high_vec[k]);
      if (alloc_hit[k]) begin
        rdata            = rdata | REG_W'(cnt_vec[k]);
        rdata[FORCE_BIT] = force_vec[k];
        rdata[OVR_BIT]   = ovr_vec[k];
      end
    end
  end
endmodule

// File: rtl/rxfc_tracker.sv
module rxfc_tracker
  import rxfc_pkg::*;
#(
  parameter int NUM_TRK = 4,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int CH_W    = $clog2(2 * NUM_TRK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_waddr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [ADDR_W-1:0]  reg_raddr,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               cons_valid,
  input  logic [CH_W-1:0]    cons_chan,
  output logic [NUM_TRK-1:0] pause_o,
  output logic [NUM_TRK-1:0] overrun_o
);
  logic                          cfg_wr;
  logic [NUM_TRK-1:0]            low_wr, high_wr, alloc_wr, force_wr;
  logic                          cfg_rd;
  logic [NUM_TRK-1:0]            low_rd, high_rd, alloc_rd;
  logic [NUM_TRK:0]              ctl_q;
  logic [NUM_TRK-1:0][CNT_W-1:0] cnt_vec, low_vec, high_vec;
  logic [NUM_TRK-1:0]            force_vec;
  logic [NUM_TRK-1:0]            cons_hit;

  rxfc_decode #(.NUM_TRK(NUM_TRK), .ADDR_W(ADDR_W)) u_wdec (
    .addr(reg_waddr), .qual(reg_we), .cfg_hit(cfg_wr),
    .low_hit(low_wr), .high_hit(high_wr), .alloc_hit(alloc_wr)
  );

  rxfc_decode #(.NUM_TRK(NUM_TRK), .ADDR_W(ADDR_W)) u_rdec (
    .addr(reg_raddr), .qual(1'b1), .cfg_hit(cfg_rd),
    .low_hit(low_rd), .high_hit(high_rd), .alloc_hit(alloc_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (cfg_wr) ctl_q <= reg_wdata[NUM_TRK:0];
  end

  for (genvar k = 0; k < NUM_TRK; k++) begin : g_unit
    assign cons_hit[k] = cons_valid && !cons_chan[0]
                         && (cons_chan[CH_W-1:1] == (CH_W-1)'(k));
    assign force_wr[k] = alloc_wr[k] && reg_wdata[FORCE_BIT];

    rxfc_credit_unit #(.CNT_W(CNT_W)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .low_we  (low_wr[k]),
      .high_we (high_wr[k]),
      .alloc_we(alloc_wr[k]),
      .wdata   (reg_wdata),
      .consume (cons_hit[k]),
      .trk_en  (ctl_q[0] && ctl_q[k+1]),
      .cnt_q   (cnt_vec[k]),
      .low_q   (low_vec[k]),
      .high_q  (high_vec[k]),
      .force_q (force_vec[k]),
      .ovr_q   (overrun_o[k]),
      .pause_q (pause_o[k])
    );
  end

  rxfc_readmux #(.NUM_TRK(NUM_TRK), .CNT_W(CNT_W)) u_rmux (
    .cfg_hit  (cfg_rd),
    .low_hit  (low_rd),
    .high_hit (high_rd),
    .alloc_hit(alloc_rd),
    .cfg_q    (ctl_q),
    .cnt_vec  (cnt_vec),
    .low_vec  (low_vec),
    .high_vec (high_vec),
    .force_vec(force_vec),
    .ovr_vec  (overrun_o),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/rxfc_chk.sv
module rxfc_chk #(
  parameter int NUM_TRK = 4,
  parameter int CNT_W   = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          glob_en,
  input logic [NUM_TRK-1:0]            pause_o,
  input logic [NUM_TRK-1:0]            overrun_o,
  input logic [NUM_TRK-1:0]            alloc_wr,
  input logic [NUM_TRK-1:0]            force_wr,
  input logic [NUM_TRK-1:0]            force_vec,
  input logic [NUM_TRK-1:0][CNT_W-1:0] cnt_vec,
  input logic [NUM_TRK-1:0][CNT_W-1:0] low_vec
);
  // R9
  pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> pause_o == '0);

  for (genvar k = 0; k < NUM_TRK; k++) begin : g_chk
    // R5
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o[k] && !force_wr[k] |=> overrun_o[k]);

    // R7
    pause_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause_o[k]) |-> $past(cnt_vec[k] < low_vec[k]));

    // R8
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_vec[k] |-> cnt_vec[k] == '0);

    // R8
    force_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_vec[k] |=> !pause_o[k]);

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_wr[k] && cnt_vec[k] != '0 |=>
        (cnt_vec[k] == $past(cnt_vec[k]) || cnt_vec[k] == $past(cnt_vec[k]) - 1'b1));
  end
endmodule

bind rxfc_tracker rxfc_chk #(.NUM_TRK(NUM_TRK), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glob_en  (ctl_q[0]),
  .pause_o  (pause_o),
  .overrun_o(overrun_o),
  .alloc_wr (alloc_wr),
  .force_wr (force_wr),
  .force_vec(force_vec),
  .cnt_vec  (cnt_vec),
  .low_vec  (low_vec)
);

// File: tb/sim_rxfc_tracker.sv
module sim_rxfc_tracker;
  localparam int NUM_TRK = 4;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 8;
  localparam int CH_W    = 3;

  localparam logic [1:0] OP_WR = 2'd0, OP_CONS = 2'd1, OP_RD = 2'd2, OP_PAUSE = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,    4'd9, 8'h00, 32'h3},          // R9 global + tracker 0
    '{OP_WR,    4'd2, 8'h04, 32'h2},          // R2 low0
    '{OP_WR,    4'd2, 8'h08, 32'h4},          // R2 high0
    '{OP_PAUSE, 4'd7, 8'h00, 32'h1},          // R7 count 0 below low
    '{OP_RD,    4'd2, 8'h04, 32'h2},          // R2
    '{OP_RD,    4'd2, 8'h08, 32'h4},          // R2
    '{OP_RD,    4'd2, 8'h00, 32'h3},          // R2
    '{OP_WR,    4'd3, 8'h0C, 32'h3},          // R3 add 3
    '{OP_RD,    4'd3, 8'h0C, 32'h3},          // R3
    '{OP_PAUSE, 4'd7, 8'h00, 32'h1},          // R7 band holds 1
    '{OP_WR,    4'd3, 8'h0C, 32'h1},          // R3 count 4
    '{OP_PAUSE, 4'd7, 8'h00, 32'h0},          // R7 reached high
    '{OP_CONS,  4'd4, 8'h00, 32'h0},          // R4 channel 0
    '{OP_RD,    4'd4, 8'h0C, 32'h3},          // R4
    '{OP_PAUSE, 4'd7, 8'h00, 32'h0},          // R7 band holds 0
    '{OP_CONS,  4'd4, 8'h00, 32'h1},          // R4 odd channel
    '{OP_RD,    4'd4, 8'h0C, 32'h3},          // R4 unchanged
    '{OP_CONS,  4'd4, 8'h00, 32'h0},
    '{OP_CONS,  4'd4, 8'h00, 32'h0},
    '{OP_PAUSE, 4'd7, 8'h00, 32'h1},          // R7 count 1 below 2
    '{OP_CONS,  4'd5, 8'h00, 32'h0},
    '{OP_CONS,  4'd5, 8'h00, 32'h0},          // R5 at zero
    '{OP_RD,    4'd5, 8'h0C, 32'h4000_0000},  // R5
    '{OP_WR,    4'd5, 8'h0C, 32'h5},
    '{OP_RD,    4'd5, 8'h0C, 32'h4000_0005},  // R5 sticky
    '{OP_WR,    4'd8, 8'h0C, 32'h8000_0000},  // R8 force
    '{OP_RD,    4'd8, 8'h0C, 32'h8000_0000},  // R8
    '{OP_PAUSE, 4'd8, 8'h00, 32'h0},          // R8
    '{OP_CONS,  4'd8, 8'h00, 32'h0},
    '{OP_RD,    4'd8, 8'h0C, 32'h8000_0000},  // R8 consume ignored
    '{OP_WR,    4'd8, 8'h0C, 32'h6},
    '{OP_RD,    4'd8, 8'h0C, 32'h6},          // R8 released
    '{OP_WR,    4'd3, 8'h0C, 32'hFF},
    '{OP_RD,    4'd3, 8'h0C, 32'hFF},         // R3 saturation
    '{OP_WR,    4'd2, 8'h34, 32'h5},
    '{OP_RD,    4'd2, 8'h34, 32'h0},          // R2 unmapped
    '{OP_RD,    4'd2, 8'h02, 32'h0},          // R2 unmapped
    '{OP_WR,    4'd9, 8'h10, 32'h3},          // low1
    '{OP_WR,    4'd9, 8'h14, 32'h5},          // high1
    '{OP_WR,    4'd9, 8'h00, 32'h5},          // global + tracker 1
    '{OP_PAUSE, 4'd9, 8'h00, 32'h2},          // R9
    '{OP_WR,    4'd9, 8'h00, 32'h4},          // global off
    '{OP_PAUSE, 4'd9, 8'h00, 32'h0},          // R9
    '{OP_WR,    4'd9, 8'h00, 32'h5},
    '{OP_PAUSE, 4'd9, 8'h00, 32'h2},          // R9
    '{OP_RD,    4'd2, 8'h00, 32'h5}           // R2
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reg_we = 1'b0;
  logic [ADDR_W-1:0]  reg_waddr = '0;
  logic [31:0]        reg_wdata = '0;
  logic [ADDR_W-1:0]  reg_raddr = '0;
  logic [31:0]        reg_rdata;
  logic               cons_valid = 1'b0;
  logic [CH_W-1:0]    cons_chan = '0;
  logic [NUM_TRK-1:0] pause_o, overrun_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  rxfc_tracker #(.NUM_TRK(NUM_TRK), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CH_W(CH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cons_valid(cons_valid), .cons_chan(cons_chan),
    .pause_o(pause_o), .overrun_o(overrun_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cons(input logic [CH_W-1:0] ch);
    @(negedge clk);
    cons_valid = 1'b1; cons_chan = ch;
    @(negedge clk);
    cons_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_raddr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 cfg", 8'h00, 32'h0);
    rd_chk("R1 low0", 8'h04, 32'h0);
    rd_chk("R1 alloc0", 8'h0C, 32'h0);
    rd_chk("R1 alloc3", 8'h30, 32'h0);
    check("R1 pause", 32'(pause_o), 32'h0);
    check("R1 overrun", 32'(overrun_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   wr(VECS[i].addr, VECS[i].data);
        OP_CONS: cons(VECS[i].data[CH_W-1:0]);
        OP_RD:   rd_chk($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
        default: begin
          @(negedge clk);
          check($sformatf("R%0d vec %0d pause", VECS[i].req, i), 32'(pause_o), VECS[i].data);
        end
      endcase
    end

    // R5 overrun output of tracker 0 was cleared by the force write
    check("R5 overrun_o", 32'(overrun_o), 32'h0);

    // R6 add and consume in one cycle on tracker 1 (count 0)
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 8'h18; reg_wdata = 32'h3;
    cons_valid = 1'b1; cons_chan = 3'd2;
    @(negedge clk);
    reg_we = 1'b0; cons_valid = 1'b0;
    rd_chk("R6 net", 8'h18, 32'h2);

    // R6 add 1 against count 0 on tracker 2: no overrun
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 8'h24; reg_wdata = 32'h1;
    cons_valid = 1'b1; cons_chan = 3'd4;
    @(negedge clk);
    reg_we = 1'b0; cons_valid = 1'b0;
    rd_chk("R6 zero net", 8'h24, 32'h0);
    check("R6 no overrun", 32'(overrun_o[2]), 32'h0);

    // R5 overrun output on tracker 3
    cons(3'd6);
    check("R5 overrun_o3", 32'(overrun_o), 32'h8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule